// File: doc/BRIEF.md
# Two-Leaf Interleaved DRAM Controller

This block sequences a DRAM array built from two 32-bit leaves, A and B. A host issues single-word read or write requests with four byte enables and a word address. The controller multiplexes row and column addresses onto a per-leaf 12-bit address bus. It drives a row strobe for each of four banks, a column strobe for each of four byte lanes and a write enable. All of these strobes are active low. A ready/wait handshake stalls the host while the controller is busy, while a periodic refresh is pending, or while the target bank is still precharging.

With interleaving enabled, the lowest word-address bit picks the leaf. Consecutive words of a burst therefore alternate between A and B, and the precharge of one leaf overlaps the access to the other. With interleaving disabled, every access goes to leaf A. Refresh is a row-strobe-only cycle on all banks of both leaves, announced by a refresh indicator one cycle in advance. Buffer controls are also produced: a per-leaf read transmit enable, and a per-leaf write latch enable. The latch enable follows the column strobe in buffer modes 0 and 1 and becomes a half-clock pulse in modes 2 and 3.

Top module: `ilv_dram_ctrl`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, and its row phase occupies the cycle that follows. The row appears on the leaf's address bus in the first two cycles and the column, zero-extended, in the cycles after that. The decoded word is `w` = (interleaved ? `req_addr>>1` : `req_addr`), with the column in `w[9:0]`, the bank in `w[11:10]` and the row in `w[23:12]`.
- R2: When interleaving is enabled, `req_addr[0]` selects the leaf, with 0 meaning A and 1 meaning B. When it is disabled, every access uses leaf A and the leaf B outputs stay idle apart from refresh. The address bus of an idle leaf reads 0.
- R3: An access drives `ras_n[bank]` low on its accessed leaf from the second cycle through the end of the column phase. All other row strobes stay high.
- R4: The column phase starts in the fourth cycle and lasts CAS_CYC cycles. During it, `cas_n[i]` is low exactly where `req_be[i]` was 1, with bit i covering byte lane i.
- R5: For a write, `we_n` of the accessed leaf is low in the third cycle and throughout the column phase. It is high otherwise.
- R6: A refresh drives `ref_n` low for one cycle with every row strobe still high. All eight row strobes then go low for REF_CYC cycles, and `ref_n` stays low during that time. Both address buses carry a refresh row counter, which starts at 0 and advances after each refresh.
- R7: After a bank's row strobe rises, that bank is not accepted again until TRP idle cycles have passed. The strobe stays high for at least TRP+1 cycles.
- R8: For a read, `tx_n` of the accessed leaf is low throughout the column phase. It is high otherwise.
- R9: In buffer modes 0 and 1 (`buf_mode[1]`=0), a write drives `le_n` of its leaf low throughout the column phase.
- R10: In buffer modes 2 and 3 (`buf_mode[1]`=1), a write drives `le_n` low only during the high half of the first column-phase clock.
- R11: A refresh request is raised every REF_INT cycles. While it is pending, `req_ready` is low. The refresh starts from idle once every bank has finished precharging, and it takes priority over host requests.
- R12: After reset all strobes and buffer controls are high, both address buses are 0 and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ilv_en | input | 1 | 1 = interleave the two leaves |
| buf_mode | input | 2 | Buffer control mode, captured on accept |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Word address |
| req_be | input | 4 | Byte enables |
| req_ready | output | 1 | Request accepted on this edge when high |
| ma_a | output | 12 | Leaf A multiplexed address |
| ras_a_n | output | 4 | Leaf A row strobes per bank |
| cas_a_n | output | 4 | Leaf A column strobes per byte |
| we_a_n | output | 1 | Leaf A write enable |
| ma_b | output | 12 | Leaf B multiplexed address |
| ras_b_n | output | 4 | Leaf B row strobes per bank |
| cas_b_n | output | 4 | Leaf B column strobes per byte |
| we_b_n | output | 1 | Leaf B write enable |
| ref_n | output | 1 | Refresh indicator, leads refresh row strobes |
| tx_a_n | output | 1 | Leaf A read buffer enable |
| tx_b_n | output | 1 | Leaf B read buffer enable |
| le_a_n | output | 1 | Leaf A write latch enable |
| le_b_n | output | 1 | Leaf B write latch enable |

## Verification
Counting from the accepting edge k, the row address appears in cycle k and the row strobe in cycle k+1. The column address and write enable appear in cycle k+2. Column strobes, transmit enable and latch enable cover cycles k+3 through k+2+CAS_CYC. The bank becomes acceptable again at cycle k+3+CAS_CYC+TRP. A refresh started at edge s shows the indicator in cycle s and the row strobes in cycles s+1 through s+REF_CYC. The bench model keeps these cycle numbers as absolute time stamps and compares every output 5 ns after each rising edge. It checks the latch enables a second time 15 ns after the edge, so the half-clock pulse is seen to end.

// File: rtl/ilv_dram_pkg.sv
package ilv_dram_pkg;

    localparam int BANKS = 4;
    localparam int LANES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_RANN,
        ST_RREF
    } phase_e;

endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int BANK_W = 2,
    localparam int EFF_W = ROW_W + BANK_W + COL_W,
    localparam int ADDR_W = EFF_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ilv_en,
    output logic              leaf,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row_ma,
    output logic [ROW_W-1:0]  col_ma
);
    logic [EFF_W-1:0] eff;

    always_comb begin
        eff    = ilv_en ? addr[ADDR_W-1:1] : addr[EFF_W-1:0];
        leaf   = ilv_en & addr[0];
        col_ma = ROW_W'(eff[COL_W-1:0]);
        bank   = eff[COL_W +: BANK_W];
        row_ma = eff[EFF_W-1 -: ROW_W];
    end
endmodule

// File: rtl/ilv_refresh_timer.sv
module ilv_refresh_timer #(
    parameter int REF_INT = 64,
    localparam int TW = $clog2(REF_INT)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic pend
);
    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          pend;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (q.tmr == '0) begin
            d.tmr  = TW'(REF_INT - 1);
            d.pend = 1'b1;
        end else begin
            d.tmr  = q.tmr - 1'b1;
            d.pend = q.pend & ~clear;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.tmr  <= TW'(REF_INT - 1);
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pend = q.pend;
endmodule

// File: rtl/ilv_bank_precharge.sv
module ilv_bank_precharge #(
    parameter int NCTR = 8,
    parameter int TRP  = 3,
    localparam int IW = $clog2(NCTR),
    localparam int CW = $clog2(TRP + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_one,
    input  logic [IW-1:0]   load_idx,
    input  logic            load_all,
    output logic [NCTR-1:0] free
);
    logic [CW-1:0] cnt_q [NCTR];
    logic [CW-1:0] cnt_d [NCTR];

    always_comb begin
        for (int i = 0; i < NCTR; i++) begin
            if (load_all || (load_one && (load_idx == IW'(i))))
                cnt_d[i] = CW'(TRP);
            else if (cnt_q[i] != '0)
                cnt_d[i] = cnt_q[i] - 1'b1;
            else
                cnt_d[i] = cnt_q[i];
            free[i] = (cnt_q[i] == '0);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCTR; i++) begin
            if (rst) cnt_q[i] <= '0;
            else     cnt_q[i] <= cnt_d[i];
        end
    end
endmodule

// File: rtl/ilv_leaf_drive.sv
module ilv_leaf_drive
    import ilv_dram_pkg::*;
#(
    parameter int MA_W = 12,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              sel,
    input  logic [BANK_W-1:0] bank,
    input  logic [LANES-1:0]  be,
    input  logic              wr,
    input  logic              pulse,
    input  logic              first_cas,
    input  logic [MA_W-1:0]   row_ma,
    input  logic [MA_W-1:0]   col_ma,
    input  logic [MA_W-1:0]   ref_ma,
    output logic [MA_W-1:0]   ma,
    output logic [BANKS-1:0]  ras_n,
    output logic [LANES-1:0]  cas_n,
    output logic              we_n,
    output logic              tx_n,
    output logic              le_n
);
    logic act, in_row, in_strobe, in_col, in_cas, arm_pulse;
    logic half_q, half_d;

    always_comb begin
        in_row    = (phase == ST_ROW) || (phase == ST_RAS);
        in_col    = (phase == ST_COL) || (phase == ST_CAS);
        in_cas    = (phase == ST_CAS);
        in_strobe = (phase == ST_RAS) || in_col;
        act       = sel && (in_row || in_col);
        arm_pulse = act && wr && pulse && first_cas;
        half_d    = arm_pulse;

        ma    = '0;
        ras_n = '1;
        cas_n = '1;
        we_n  = 1'b1;
        tx_n  = 1'b1;
        le_n  = 1'b1;

        if ((phase == ST_RANN) || (phase == ST_RREF)) begin
            ma = ref_ma;
            if (phase == ST_RREF) ras_n = '0;
        end else if (act) begin
            ma = in_row ? row_ma : col_ma;
            if (in_strobe) ras_n[bank] = 1'b0;
            if (wr && in_col) we_n = 1'b0;
            if (in_cas) begin
                cas_n = ~be;
                if (!wr) tx_n = 1'b0;
                if (wr && !pulse) le_n = 1'b0;
            end
            if (arm_pulse && !half_q) le_n = 1'b0;
        end
    end

    // the pulse ends at the falling edge inside its own clock
    always_ff @(negedge clk) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= half_d;
    end
endmodule

// File: rtl/ilv_dram_ctrl.sv
module ilv_dram_ctrl
    import ilv_dram_pkg::*;
#(
    parameter int ROW_W   = 12,
    parameter int COL_W   = 10,
    parameter int CAS_CYC = 2,
    parameter int TRP     = 3,
    parameter int REF_INT = 64,
    parameter int REF_CYC = 3,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ADDR_W = ROW_W + BANK_W + COL_W + 1,
    localparam int MA_W   = ROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ilv_en,
    input  logic [1:0]        buf_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    output logic [MA_W-1:0]   ma_a,
    output logic [BANKS-1:0]  ras_a_n,
    output logic [LANES-1:0]  cas_a_n,
    output logic              we_a_n,
    output logic [MA_W-1:0]   ma_b,
    output logic [BANKS-1:0]  ras_b_n,
    output logic [LANES-1:0]  cas_b_n,
    output logic              we_b_n,
    output logic              ref_n,
    output logic              tx_a_n,
    output logic              tx_b_n,
    output logic              le_a_n,
    output logic              le_b_n
);
    localparam int CYC_MAX = (CAS_CYC > REF_CYC) ? CAS_CYC : REF_CYC;
    localparam int CNT_W   = $clog2(CYC_MAX) + 1;
    localparam int NPC     = 2 * BANKS;
    localparam int PCI_W   = $clog2(NPC);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic               leaf;
        logic [BANK_W-1:0]  bank;
        logic [MA_W-1:0]    row;
        logic [MA_W-1:0]    col;
        logic [LANES-1:0]   be;
        logic               wr;
        logic               pulse;
        logic [MA_W-1:0]    rrow;
    } ctl_t;

    ctl_t q, d;

    logic              in_leaf;
    logic [BANK_W-1:0] in_bank;
    logic [MA_W-1:0]   in_row, in_col;
    logic              ref_pend, start_ref, accept, first_cas;
    logic              load_one, load_all;
    logic [NPC-1:0]    bank_free;
    logic              unused_mode_lo;

    assign unused_mode_lo = buf_mode[0];

    ilv_addr_map #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_map (
        .addr   (req_addr),
        .ilv_en (ilv_en),
        .leaf   (in_leaf),
        .bank   (in_bank),
        .row_ma (in_row),
        .col_ma (in_col)
    );

    ilv_refresh_timer #(.REF_INT(REF_INT)) u_rtmr (
        .clk   (clk),
        .rst   (rst),
        .clear (start_ref),
        .pend  (ref_pend)
    );

    ilv_bank_precharge #(.NCTR(NPC), .TRP(TRP)) u_pchg (
        .clk      (clk),
        .rst      (rst),
        .load_one (load_one),
        .load_idx ({q.leaf, q.bank}),
        .load_all (load_all),
        .free     (bank_free)
    );

    always_comb begin
        d         = q;
        load_one  = 1'b0;
        load_all  = 1'b0;
        first_cas = (q.phase == ST_CAS) && (q.cnt == CNT_W'(CAS_CYC - 1));
        start_ref = (q.phase == ST_IDLE) && ref_pend && (&bank_free);
        req_ready = (q.phase == ST_IDLE) && !ref_pend
                    && bank_free[PCI_W'({in_leaf, in_bank})];
        accept    = req_valid && req_ready;

        case (q.phase)
            ST_IDLE: begin
                if (start_ref) begin
                    d.phase = ST_RANN;
                end else if (accept) begin
                    d.phase = ST_ROW;
                    d.leaf  = in_leaf;
                    d.bank  = in_bank;
                    d.row   = in_row;
                    d.col   = in_col;
                    d.be    = req_be;
                    d.wr    = req_write;
                    d.pulse = buf_mode[1];
                end
            end
            ST_ROW: d.phase = ST_RAS;
            ST_RAS: d.phase = ST_COL;
            ST_COL: begin
                d.phase = ST_CAS;
                d.cnt   = CNT_W'(CAS_CYC - 1);
            end
            ST_CAS: begin
                if (q.cnt == '0) begin
                    d.phase  = ST_IDLE;
                    load_one = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RANN: begin
                d.phase = ST_RREF;
                d.cnt   = CNT_W'(REF_CYC - 1);
            end
            ST_RREF: begin
                if (q.cnt == '0) begin
                    d.phase  = ST_IDLE;
                    d.rrow   = q.rrow + 1'b1;
                    load_all = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.phase <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    logic [MA_W-1:0]  ma_w    [2];
    logic [BANKS-1:0] ras_w   [2];
    logic [LANES-1:0] cas_w   [2];
    logic [1:0]       we_w, tx_w, le_w;

    for (genvar g = 0; g < 2; g++) begin : g_leaf
        ilv_leaf_drive #(.MA_W(MA_W)) u_drv (
            .clk       (clk),
            .rst       (rst),
            .phase     (q.phase),
            .sel       (q.leaf == 1'(g)),
            .bank      (q.bank),
            .be        (q.be),
            .wr        (q.wr),
            .pulse     (q.pulse),
            .first_cas (first_cas),
            .row_ma    (q.row),
            .col_ma    (q.col),
            .ref_ma    (q.rrow),
            .ma        (ma_w[g]),
            .ras_n     (ras_w[g]),
            .cas_n     (cas_w[g]),
            .we_n      (we_w[g]),
            .tx_n      (tx_w[g]),
            .le_n      (le_w[g])
        );
    end

    assign ma_a    = ma_w[0];
    assign ras_a_n = ras_w[0];
    assign cas_a_n = cas_w[0];
    assign we_a_n  = we_w[0];
    assign tx_a_n  = tx_w[0];
    assign le_a_n  = le_w[0];
    assign ma_b    = ma_w[1];
    assign ras_b_n = ras_w[1];
    assign cas_b_n = cas_w[1];
    assign we_b_n  = we_w[1];
    assign tx_b_n  = tx_w[1];
    assign le_b_n  = le_w[1];
    assign ref_n   = !((q.phase == ST_RANN) || (q.phase == ST_RREF));
endmodule

// File: rtl/ilv_dram_chk.sv
module ilv_dram_chk #(
    parameter int TRP = 3,
    localparam int GW = $clog2(TRP + 3)
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] ras_a_n,
    input logic [3:0] ras_b_n,
    input logic [3:0] cas_a_n,
    input logic [3:0] cas_b_n,
    input logic       we_a_n,
    input logic       we_b_n,
    input logic       tx_a_n,
    input logic       tx_b_n,
    input logic       ref_n
);
    // R3
    ras_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        ref_n |-> ($onehot0(~ras_a_n) && $onehot0(~ras_b_n)));

    // R4
    cas_in_row_chk: assert property (@(posedge clk) disable iff (rst)
        ((cas_a_n != 4'hF) || (cas_b_n != 4'hF))
            |-> ((cas_a_n == 4'hF || ras_a_n != 4'hF) && (cas_b_n == 4'hF || ras_b_n != 4'hF)));

    // R5
    we_in_row_chk: assert property (@(posedge clk) disable iff (rst)
        (!we_a_n || !we_b_n) |-> ((we_a_n || ras_a_n != 4'hF) && (we_b_n || ras_b_n != 4'hF)));

    // R6
    ref_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_n) |-> (ras_a_n == 4'hF && ras_b_n == 4'hF));

    // R6
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_n && ras_a_n == 4'h0) |-> !$past(ref_n));

    // R8
    tx_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!tx_a_n && !tx_b_n) && (tx_a_n || we_a_n) && (tx_b_n || we_b_n));

    logic [7:0] line;
    assign line = {ras_b_n, ras_a_n};

    for (genvar i = 0; i < 8; i++) begin : g_gap
        logic [GW-1:0] gap_q;
        always_ff @(posedge clk) begin
            if (rst)            gap_q <= GW'(TRP + 2);
            else if (!line[i])  gap_q <= '0;
            else if (gap_q != GW'(TRP + 2)) gap_q <= gap_q + 1'b1;
        end
        // R7
        precharge_gap_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(line[i]) |-> (gap_q >= GW'(TRP + 1)));
    end
endmodule

bind ilv_dram_ctrl ilv_dram_chk #(.TRP(TRP)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ras_a_n (ras_a_n),
    .ras_b_n (ras_b_n),
    .cas_a_n (cas_a_n),
    .cas_b_n (cas_b_n),
    .we_a_n  (we_a_n),
    .we_b_n  (we_b_n),
    .tx_a_n  (tx_a_n),
    .tx_b_n  (tx_b_n),
    .ref_n   (ref_n)
);

// File: tb/sim_ilv_dram_ctrl.sv
`timescale 1ns/1ps
module sim_ilv_dram_ctrl;
    localparam int CAS_CYC = 2;
    localparam int TRP     = 3;
    localparam int REF_INT = 64;
    localparam int REF_CYC = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ilv_en = 1'b1;
    logic [1:0]  buf_mode = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [24:0] req_addr = '0;
    logic [3:0]  req_be = 4'hF;
    logic        req_ready;
    logic [11:0] ma_a, ma_b;
    logic [3:0]  ras_a_n, ras_b_n, cas_a_n, cas_b_n;
    logic        we_a_n, we_b_n, ref_n, tx_a_n, tx_b_n, le_a_n, le_b_n;

    ilv_dram_ctrl #(.CAS_CYC(CAS_CYC), .TRP(TRP), .REF_INT(REF_INT), .REF_CYC(REF_CYC)) u0 (
        .clk(clk), .rst(rst), .ilv_en(ilv_en), .buf_mode(buf_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_ready(req_ready),
        .ma_a(ma_a), .ras_a_n(ras_a_n), .cas_a_n(cas_a_n), .we_a_n(we_a_n),
        .ma_b(ma_b), .ras_b_n(ras_b_n), .cas_b_n(cas_b_n), .we_b_n(we_b_n),
        .ref_n(ref_n), .tx_a_n(tx_a_n), .tx_b_n(tx_b_n), .le_a_n(le_a_n), .le_b_n(le_b_n)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at cycle: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model (absolute time stamps) ----------------
    int   e = 0, busy_end = 0, acc_k = -1000, ref_k = -1000, nref = 0, ref_row = 0;
    int   free_at [8];
    bit   rpend = 0;
    bit   m_leaf, m_wr, m_pulse;
    int   m_bank, m_row, m_col;
    logic [3:0] m_be;

    function automatic void dec(input logic [24:0] a, input logic il,
                                output bit lf, output int bk, output int rw, output int cl);
        logic [24:0] w;
        w  = il ? (a >> 1) : a;
        lf = il ? a[0] : 1'b0;
        cl = int'(w[9:0]);
        bk = int'(w[11:10]);
        rw = int'(w[23:12]);
    endfunction

    function automatic bit all_free(input int c);
        for (int i = 0; i < 8; i++) if (free_at[i] > c) return 0;
        return 1;
    endfunction

    function automatic bit exp_ready(input int c);
        bit lf; int bk, rw, cl;
        dec(req_addr, ilv_en, lf, bk, rw, cl);
        return (c >= busy_end) && !rpend && (c >= free_at[lf * 4 + bk]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            e = 0; busy_end = 0; acc_k = -1000; ref_k = -1000; nref = 0; rpend = 0;
            for (int i = 0; i < 8; i++) free_at[i] = 0;
        end else begin
            bit sref, rdy;
            sref = (e >= busy_end) && rpend && all_free(e);
            rdy  = exp_ready(e);
            e = e + 1;
            if (sref) begin
                ref_k = e; ref_row = nref % 4096; nref++;
                busy_end = e + 1 + REF_CYC;
                for (int i = 0; i < 8; i++) free_at[i] = busy_end + TRP;
            end else if (req_valid && rdy) begin
                dec(req_addr, ilv_en, m_leaf, m_bank, m_row, m_col);
                m_be = req_be; m_wr = req_write; m_pulse = buf_mode[1];
                acc_k = e;
                busy_end = e + 3 + CAS_CYC;
                free_at[m_leaf * 4 + m_bank] = busy_end + TRP;
            end
            rpend = (rpend && !sref) || (e % REF_INT == 0);
        end
    end

    logic [11:0] ema [2];
    logic [3:0]  eras [2], ecas [2];
    logic        ewe [2], etx [2], ele [2];
    logic        eref;

    task automatic calc();
        for (int l = 0; l < 2; l++) begin
            ema[l] = '0; eras[l] = 4'hF; ecas[l] = 4'hF; ewe[l] = 1; etx[l] = 1; ele[l] = 1;
        end
        eref = 1;
        if (e >= ref_k && e <= ref_k + REF_CYC) begin
            eref = 0;
            for (int l = 0; l < 2; l++) begin
                ema[l] = 12'(ref_row);
                if (e > ref_k) eras[l] = 4'h0;
            end
        end
        if (e >= acc_k && e < acc_k + 3 + CAS_CYC) begin
            int ph; ph = e - acc_k;
            ema[m_leaf] = (ph < 2) ? 12'(m_row) : 12'(m_col);
            if (ph >= 1) eras[m_leaf][m_bank] = 1'b0;
            if (m_wr && ph >= 2) ewe[m_leaf] = 0;
            if (ph >= 3) begin
                ecas[m_leaf] = ~m_be;
                if (!m_wr) etx[m_leaf] = 0;
                if (m_wr) ele[m_leaf] = m_pulse ? (ph != 3) : 1'b0;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst && !done) begin
            #5;
            calc();
            cmp("R1 R2 ma_a", 32'(ma_a), 32'(ema[0]));
            cmp("R1 R2 ma_b", 32'(ma_b), 32'(ema[1]));
            cmp("R3 R6 ras_a_n", 32'(ras_a_n), 32'(eras[0]));
            cmp("R3 R6 ras_b_n", 32'(ras_b_n), 32'(eras[1]));
            cmp("R4 cas_a_n", 32'(cas_a_n), 32'(ecas[0]));
            cmp("R4 cas_b_n", 32'(cas_b_n), 32'(ecas[1]));
            cmp("R5 we_a_n", 32'(we_a_n), 32'(ewe[0]));
            cmp("R5 we_b_n", 32'(we_b_n), 32'(ewe[1]));
            cmp("R6 ref_n", 32'(ref_n), 32'(eref));
            cmp("R8 tx_a_n", 32'(tx_a_n), 32'(etx[0]));
            cmp("R8 tx_b_n", 32'(tx_b_n), 32'(etx[1]));
            cmp("R9 R10 le_a_n high phase", 32'(le_a_n), 32'(ele[0]));
            cmp("R9 R10 le_b_n high phase", 32'(le_b_n), 32'(ele[1]));
            cmp("R7 R11 req_ready", 32'(req_ready), 32'(exp_ready(e)));
            #10;
            // second half of the clock: a half-clock pulse has ended
            cmp("R10 le_a_n low phase", 32'(le_a_n), 32'(m_pulse ? 1'b1 : ele[0]));
            cmp("R10 le_b_n low phase", 32'(le_b_n), 32'(m_pulse ? 1'b1 : ele[1]));
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [24:0] a, input logic [3:0] be, input logic [1:0] md);
        bit got;
        int waited;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_be = be; buf_mode = md;
        got = 0; waited = 0;
        while (!got && waited < 300) begin
            #9;
            got = req_ready;
            @(posedge clk);
            waited++;
        end
        if (!got) begin
            n_checks++; n_fails++;
            $display("FAIL R11 request never accepted: actual 0 expected 1");
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R12 reset state
        cmp("R12 reset ras", 32'({ras_a_n, ras_b_n, cas_a_n, cas_b_n}), 32'hFFFF);
        cmp("R12 reset ctl", 32'({we_a_n, we_b_n, ref_n, tx_a_n, tx_b_n, le_a_n, le_b_n}), 32'h7F);
        cmp("R12 reset ma", 32'({ma_a, ma_b}), 32'h0);
        cmp("R12 reset ready", 32'(req_ready), 32'h1);
        @(negedge clk);
        rst = 0;

        ilv_en = 1;
        for (int i = 0; i < 4; i++) issue(1, 25'h100 + 25'(i), 4'hF, 2'd0);   // R2 R9
        for (int i = 0; i < 4; i++) issue(0, 25'h100 + 25'(i), 4'hF, 2'd0);   // R8
        issue(1, 25'h0ABC01, 4'b0101, 2'd2);                                   // R4 R10
        issue(1, 25'h1234567, 4'b1000, 2'd3);                                  // R10
        issue(0, 25'h000400, 4'hF, 2'd1);                                      // R7 same bank
        issue(0, 25'h000402, 4'hF, 2'd1);
        ilv_en = 0;
        issue(1, 25'h000801, 4'b0011, 2'd0);                                   // R2 leaf A only
        issue(0, 25'h000803, 4'hF, 2'd2);
        issue(1, 25'h000C00, 4'b1100, 2'd3);
        repeat (200) @(posedge clk);                                           // R6 R11
        for (int i = 0; i < 120; i++) begin
            ilv_en = (i % 5) != 0;
            issue((i % 3) == 0, 25'((i * 40503 + 17) ^ (i << 13)), 4'((i % 15) + 1), 2'(i % 4));
            if (i % 17 == 0) repeat (i % 7) @(posedge clk);
        end
        repeat (20) @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule